// File: doc/BRIEF.md
# Flit Segmenting Port

This block moves network flits across a narrow chip-boundary bus so that fewer I/O pins are needed. The transmit half accepts one parallel flit through a valid/ready handshake. It builds a framed word and drives it onto a `PIN_W`-bit bus, one slice per clock, starting with the most significant bit. The word holds a start bit, the flow-segment number (the virtual connection), a last-flit flag, the data bits, and zero padding up to a whole number of slices. The receive half watches a bus of the same width. When it sees the start bit it gathers the rest of the slices, drops the padding, and presents the rebuilt flit with a one-cycle valid strobe.

The transmitter has two states. `TX_IDLE` goes to `TX_SEND` on an accepted flit. `TX_SEND` returns to `TX_IDLE` after the final slice. The receiver also has two states. `RX_HUNT` goes to `RX_GATHER` when the top pin is set. `RX_GATHER` returns to `RX_HUNT` after the final slice. With a single-slice frame, `RX_HUNT` delivers the flit directly.

The lengths are derived from the parameters. The framed length is `FRAME_LEN = SEG_W + DATA_W + 2`. The slice count is `BEATS = ceil(FRAME_LEN / PIN_W)`. With the defaults (4 pins, 3-bit segment, 8-bit data) this gives 13 framed bits, 4 slices and 3 padding bits.

Top module: `flit_seg_port`

## Requirements
- R1: While `rst_n` is low, `tx_ready` is 1, `tx_pins` is 0, `rx_valid` is 0, and `rx_seg`, `rx_last` and `rx_data` are 0.
- R2: A flit is accepted at a rising edge where `tx_valid` and `tx_ready` are both 1. During the next `BEATS` cycles, `tx_pins` carries slice k = 0..BEATS-1 of the padded word {1'b1, seg, last, data, PAD_LEN zero bits}, taken from its most significant end.
- R3: After an accept, `tx_ready` is 0 for exactly `BEATS` cycles and then returns to 1. Whenever `tx_ready` is 1, `tx_pins` is 0.
- R4: Changes to `tx_valid`, `tx_seg`, `tx_last` and `tx_data` while `tx_ready` is 0 do not alter the slices being sent.
- R5: In `RX_HUNT`, a slice whose top bit (`rx_pins[PIN_W-1]`) is 0 is ignored. It raises no `rx_valid` and changes no output field.
- R6: `rx_valid` is 1 for exactly one cycle, in the cycle after the edge that samples the final slice. A new start bit may arrive in that same cycle, and that frame is received as well.
- R7: The low `PAD_LEN` bits of the final slice are ignored. Padding set to ones gives the same fields as padding set to zeros.
- R8: A set top bit in slices 1..BEATS-1 of a frame is taken as data and does not restart framing.
- R9: `rx_seg`, `rx_last` and `rx_data` hold their values in every cycle where `rx_valid` is 0.
- R10: With `tx_pins` looped to `rx_pins`, `rx_valid` is 1 after the `BEATS`-th edge following the accepting edge. The fields then equal the accepted seg, last and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Parallel flit offered for transmit |
| tx_ready | output | 1 | Transmitter can accept a flit |
| tx_seg | input | SEG_W | Flow-segment number to send |
| tx_last | input | 1 | Last-flit flag to send |
| tx_data | input | DATA_W | Data bits to send |
| tx_pins | output | PIN_W | Narrow outgoing bus |
| rx_pins | input | PIN_W | Narrow incoming bus |
| rx_valid | output | 1 | One-cycle strobe for a rebuilt flit |
| rx_seg | output | SEG_W | Received flow-segment number |
| rx_last | output | 1 | Received last-flit flag |
| rx_data | output | DATA_W | Received data bits |

## Verification
The assertions check, on every cycle, the following behaviours:
- the transmit handshake drops after an accept;
- the first slice carries the start bit;
- the bus is quiet whenever the transmitter is ready;
- the busy window lasts exactly `BEATS` cycles;
- the receive strobe is a single-cycle pulse;
- the received fields hold between pulses.

Only the bench scenarios can show three further things. The first is that the bit order and padding of each frame are right for every segment, flag and data value. The second is that noise, ones in the padding and set top bits inside a frame do not corrupt reception. The third is that back-to-back received frames and the loopback latency behave as specified.

// File: rtl/flit_seg_pkg.sv
package flit_seg_pkg;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_e;

    typedef enum logic {
        RX_HUNT,
        RX_GATHER
    } rx_state_e;

    // Number of pin-wide slices needed to carry len bits.
    function automatic int frame_beats(input int len, input int width);
        return (len + width - 1) / width;
    endfunction

endpackage

// File: rtl/flit_seg_beat_ctr.sv
module flit_seg_beat_ctr #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic at_limit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] count;

    assign at_limit = (count == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (step) begin
            count <= at_limit ? '0 : count + CW'(1);
        end
    end
endmodule

// File: rtl/flit_seg_tx.sv
module flit_seg_tx
    import flit_seg_pkg::*;
#(
    parameter int PIN_W  = 4,
    parameter int SEG_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SEG_W-1:0]  in_seg,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    output logic [PIN_W-1:0]  pins
);
    localparam int FRAME_LEN = SEG_W + DATA_W + 2;
    localparam int BEATS     = frame_beats(FRAME_LEN, PIN_W);
    localparam int PADDED    = BEATS * PIN_W;
    localparam int PAD_LEN   = PADDED - FRAME_LEN;

    tx_state_e              state, state_nxt;
    logic [PADDED-1:0]      shreg;
    logic [FRAME_LEN-1:0]   frame;
    logic                   accept;
    logic                   sending;
    logic                   final_beat;

    assign accept  = in_valid && (state == TX_IDLE);
    assign sending = (state == TX_SEND);
    assign frame   = {1'b1, in_seg, in_last, in_data};

    flit_seg_beat_ctr #(.LIMIT(BEATS)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .step     (sending),
        .at_limit (final_beat)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions: accept (IDLE->SEND), final slice (SEND->IDLE)
    always_comb begin
        state_nxt = state;
        unique case (state)
            TX_IDLE: if (in_valid)   state_nxt = TX_SEND;
            TX_SEND: if (final_beat) state_nxt = TX_IDLE;
            default:                 state_nxt = TX_IDLE;
        endcase
    end

    // Frame shift register: loaded padded on accept, shifted each slice
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (accept) begin
            shreg <= PADDED'(frame) << PAD_LEN;
        end else if (sending) begin
            shreg <= shreg << PIN_W;
        end
    end

    // Outputs
    always_comb begin
        in_ready = (state == TX_IDLE);
        pins     = sending ? shreg[PADDED-1 -: PIN_W] : '0;
    end
endmodule

// File: rtl/flit_seg_rx.sv
module flit_seg_rx
    import flit_seg_pkg::*;
#(
    parameter int PIN_W  = 4,
    parameter int SEG_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pins,
    output logic              out_valid,
    output logic [SEG_W-1:0]  out_seg,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data
);
    localparam int FRAME_LEN = SEG_W + DATA_W + 2;
    localparam int BEATS     = frame_beats(FRAME_LEN, PIN_W);
    localparam int PADDED    = BEATS * PIN_W;
    localparam int PAD_LEN   = PADDED - FRAME_LEN;
    localparam bit SINGLE    = (BEATS == 1);
    localparam int GATHER_N  = SINGLE ? 1 : BEATS - 1;

    rx_state_e              state, state_nxt;
    logic [PADDED-1:0]      shreg;
    logic [PADDED-1:0]      assembled;
    logic [FRAME_LEN-2:0]   body;
    logic                   start_seen;
    logic                   hunting;
    logic                   gather_done;
    logic                   complete;

    assign hunting    = (state == RX_HUNT);
    assign start_seen = pins[PIN_W-1];

    flit_seg_beat_ctr #(.LIMIT(GATHER_N)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (hunting),
        .step     (state == RX_GATHER),
        .at_limit (gather_done)
    );

    // Word as it stands once the current slice is included; padding
    // and the start bit fall away in the body extraction.
    always_comb begin
        assembled = hunting ? PADDED'(pins) : ((shreg << PIN_W) | PADDED'(pins));
        body      = (FRAME_LEN - 1)'(assembled >> PAD_LEN);
        complete  = hunting ? (start_seen && SINGLE) : gather_done;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_HUNT;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions: start bit (HUNT->GATHER), final slice (GATHER->HUNT)
    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_HUNT:   if (start_seen && !SINGLE) state_nxt = RX_GATHER;
            RX_GATHER: if (gather_done)           state_nxt = RX_HUNT;
            default:                              state_nxt = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (!hunting || start_seen) begin
            shreg <= assembled;
        end
    end

    // Outputs: registered fields with a one-cycle strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_seg   <= '0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= complete;
            if (complete) begin
                out_seg  <= body[FRAME_LEN-2 -: SEG_W];
                out_last <= body[DATA_W];
                out_data <= body[DATA_W-1:0];
            end
        end
    end
endmodule

// File: rtl/flit_seg_port.sv
module flit_seg_port #(
    parameter int PIN_W  = 4,
    parameter int SEG_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [SEG_W-1:0]  tx_seg,
    input  logic              tx_last,
    input  logic [DATA_W-1:0] tx_data,
    output logic [PIN_W-1:0]  tx_pins,
    input  logic [PIN_W-1:0]  rx_pins,
    output logic              rx_valid,
    output logic [SEG_W-1:0]  rx_seg,
    output logic              rx_last,
    output logic [DATA_W-1:0] rx_data
);
    flit_seg_tx #(.PIN_W(PIN_W), .SEG_W(SEG_W), .DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_valid),
        .in_ready (tx_ready),
        .in_seg   (tx_seg),
        .in_last  (tx_last),
        .in_data  (tx_data),
        .pins     (tx_pins)
    );

    flit_seg_rx #(.PIN_W(PIN_W), .SEG_W(SEG_W), .DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      (rx_pins),
        .out_valid (rx_valid),
        .out_seg   (rx_seg),
        .out_last  (rx_last),
        .out_data  (rx_data)
    );
endmodule

// File: rtl/flit_seg_port_chk.sv
module flit_seg_port_chk
    import flit_seg_pkg::*;
#(
    parameter int PIN_W  = 4,
    parameter int SEG_W  = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [PIN_W-1:0]  tx_pins,
    input logic              rx_valid,
    input logic [SEG_W-1:0]  rx_seg,
    input logic              rx_last,
    input logic [DATA_W-1:0] rx_data
);
    localparam int BEATS = frame_beats(SEG_W + DATA_W + 2, PIN_W);
    localparam int RW    = $clog2(BEATS + 2) + 1;

    logic [RW-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (tx_ready) begin
            busy_run <= '0;
        end else if (busy_run != '1) begin
            busy_run <= busy_run + RW'(1);
        end
    end

    // R3
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> tx_pins[PIN_W-1]);

    // R3
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (tx_pins == '0));

    // R3
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> (busy_run == RW'(BEATS)));

    // R9
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_seg) && $stable(rx_last) && $stable(rx_data)));

    generate
        if (BEATS > 1) begin : g_pulse
            // R6
            single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rx_valid |=> !rx_valid);
        end
    endgenerate
endmodule

bind flit_seg_port flit_seg_port_chk #(
    .PIN_W  (PIN_W),
    .SEG_W  (SEG_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_pins  (tx_pins),
    .rx_valid (rx_valid),
    .rx_seg   (rx_seg),
    .rx_last  (rx_last),
    .rx_data  (rx_data)
);

// File: tb/flit_seg_port_test.sv
`timescale 1ns/1ps
module flit_seg_port_test;
    localparam int PIN_W     = 4;
    localparam int SEG_W     = 3;
    localparam int DATA_W    = 8;
    localparam int FRAME_LEN = SEG_W + DATA_W + 2;
    localparam int BEATS     = (FRAME_LEN + PIN_W - 1) / PIN_W;
    localparam int PADDED    = BEATS * PIN_W;
    localparam int PAD_LEN   = PADDED - FRAME_LEN;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n;
    logic              tx_valid;
    logic              tx_ready;
    logic [SEG_W-1:0]  tx_seg;
    logic              tx_last;
    logic [DATA_W-1:0] tx_data;
    logic [PIN_W-1:0]  tx_pins;
    logic [PIN_W-1:0]  rx_pins;
    logic [PIN_W-1:0]  drv;
    logic              loop_en;
    logic              rx_valid;
    logic [SEG_W-1:0]  rx_seg;
    logic              rx_last;
    logic [DATA_W-1:0] rx_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    assign rx_pins = loop_en ? tx_pins : drv;

    flit_seg_port #(.PIN_W(PIN_W), .SEG_W(SEG_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_seg(tx_seg),
        .tx_last(tx_last), .tx_data(tx_data), .tx_pins(tx_pins),
        .rx_pins(rx_pins), .rx_valid(rx_valid), .rx_seg(rx_seg),
        .rx_last(rx_last), .rx_data(rx_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [PADDED-1:0] frame_word(input int seg, input bit last, input int data);
        logic [PADDED-1:0] w;
        w = PADDED'(1) << (FRAME_LEN - 1);
        w = w | (PADDED'(seg) << (DATA_W + 1));
        w = w | (PADDED'(last) << DATA_W);
        w = w | PADDED'(data);
        return w << PAD_LEN;
    endfunction

    function automatic logic [PIN_W-1:0] slice_of(input logic [PADDED-1:0] w, input int k);
        return PIN_W'(w >> ((BEATS - 1 - k) * PIN_W));
    endfunction

    // Called at a negedge with the transmitter idle.
    task automatic send_frame(input int seg, input bit last, input int data, input bit meddle);
        logic [PADDED-1:0] got;
        logic [PADDED-1:0] exp;
        bit busy_ok;
        bit rx_quiet;
        exp      = frame_word(seg, last, data);
        got      = '0;
        busy_ok  = 1'b1;
        rx_quiet = 1'b1;
        chk(tx_ready === 1'b1, "R3 ready before accept", longint'(tx_ready), 1);
        tx_valid = 1'b1;
        tx_seg   = SEG_W'(seg);
        tx_last  = last;
        tx_data  = DATA_W'(data);
        for (int k = 0; k < BEATS; k++) begin
            @(negedge clk);
            if (k == 0) begin
                if (meddle) begin
                    tx_seg  = ~tx_seg;
                    tx_last = ~tx_last;
                    tx_data = ~tx_data;
                end else begin
                    tx_valid = 1'b0;
                end
            end
            got = (got << PIN_W) | PADDED'(tx_pins);
            if (tx_ready !== 1'b0) busy_ok = 1'b0;
            if (loop_en && rx_valid !== 1'b0) rx_quiet = 1'b0;
        end
        if (meddle)
            chk(got === exp, "R4 slices unaffected by inputs while busy", longint'(got), longint'(exp));
        else
            chk(got === exp, "R2 transmitted slices", longint'(got), longint'(exp));
        chk(busy_ok, "R3 ready low for BEATS cycles", longint'(busy_ok), 1);
        if (loop_en)
            chk(rx_quiet, "R6 rx_valid low while frame in flight", longint'(rx_quiet), 1);
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready === 1'b1 && tx_pins === '0, "R3 ready back and bus quiet",
            longint'({tx_ready, tx_pins}), longint'({1'b1, {PIN_W{1'b0}}}));
        if (loop_en)
            chk(rx_valid === 1'b1 && rx_seg === SEG_W'(seg) && rx_last === last && rx_data === DATA_W'(data),
                "R10 loopback flit after BEATS edges",
                longint'({rx_valid, rx_seg, rx_last, rx_data}),
                longint'({1'b1, SEG_W'(seg), last, DATA_W'(data)}));
    endtask

    // Drives slices starting at a negedge; returns at the negedge where
    // the strobe is due. quiet reports rx_valid low on the way.
    task automatic drive_frame(input logic [PADDED-1:0] w, output bit quiet);
        quiet = 1'b1;
        for (int k = 0; k < BEATS; k++) begin
            drv = slice_of(w, k);
            @(negedge clk);
            if (k < BEATS - 1 && rx_valid !== 1'b0) quiet = 1'b0;
        end
    endtask

    task automatic expect_rx(input string tag, input int seg, input bit last, input int data);
        chk(rx_valid === 1'b1 && rx_seg === SEG_W'(seg) && rx_last === last && rx_data === DATA_W'(data), tag,
            longint'({rx_valid, rx_seg, rx_last, rx_data}),
            longint'({1'b1, SEG_W'(seg), last, DATA_W'(data)}));
    endtask

    initial begin
        bit quiet;
        bit noise_ok;
        logic [SEG_W+DATA_W:0] held;
        rst_n    = 1'b0;
        tx_valid = 1'b0;
        tx_seg   = '0;
        tx_last  = 1'b0;
        tx_data  = '0;
        drv      = '0;
        loop_en  = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(tx_ready === 1'b1 && tx_pins === '0 && rx_valid === 1'b0 &&
            rx_seg === '0 && rx_last === 1'b0 && rx_data === '0, "R1 reset state",
            longint'({tx_ready, tx_pins, rx_valid, rx_seg, rx_last, rx_data}),
            longint'({1'b1, {PIN_W{1'b0}}, 1'b0, {SEG_W{1'b0}}, 1'b0, {DATA_W{1'b0}}}));
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R10: every segment, flag and data value through the loop
        for (int s = 0; s < (1 << SEG_W); s++)
            for (int l = 0; l < 2; l++)
                for (int d = 0; d < (1 << DATA_W); d++)
                    send_frame(s, l[0], d, 1'b0);

        // R4: inputs toggled while busy
        send_frame(3, 1'b1, 8'h5A, 1'b1);
        send_frame(6, 1'b0, 8'hC3, 1'b1);

        // R5: noise with top pin clear while hunting
        loop_en = 1'b0;
        drv     = '0;
        @(negedge clk);
        held     = {rx_seg, rx_last, rx_data};
        noise_ok = 1'b1;
        for (int v = 0; v < (1 << (PIN_W - 1)); v++) begin
            drv = PIN_W'(v);
            @(negedge clk);
            if (rx_valid !== 1'b0) noise_ok = 1'b0;
        end
        drv = '0;
        repeat (BEATS + 1) begin
            @(negedge clk);
            if (rx_valid !== 1'b0) noise_ok = 1'b0;
        end
        chk(noise_ok, "R5 no strobe from idle noise", longint'(noise_ok), 1);
        chk({rx_seg, rx_last, rx_data} === held, "R5 fields untouched by noise",
            longint'({rx_seg, rx_last, rx_data}), longint'(held));

        // R7: padding bits set to ones
        drive_frame(frame_word(5, 1'b1, 8'hA5) | PADDED'((1 << PAD_LEN) - 1), quiet);
        expect_rx("R7 padding ignored", 5, 1'b1, 8'hA5);
        drv = '0;
        @(negedge clk);

        // R8: top pin set in later slices, then R6 back-to-back frame
        drive_frame(frame_word(7, 1'b1, 8'hFF), quiet);
        chk(quiet, "R8 no early strobe from inner top bits", longint'(quiet), 1);
        expect_rx("R8 inner top bits taken as data", 7, 1'b1, 8'hFF);
        drive_frame(frame_word(2, 1'b0, 8'h3C), quiet);
        chk(quiet, "R6 strobe lasts one cycle", longint'(quiet), 1);
        expect_rx("R6 back-to-back frame received", 2, 1'b0, 8'h3C);

        // R9: fields hold after the strobe
        drv = '0;
        repeat (3) @(negedge clk);
        chk(rx_valid === 1'b0 && rx_seg === 3'd2 && rx_last === 1'b0 && rx_data === 8'h3C,
            "R9 fields hold between strobes",
            longint'({rx_valid, rx_seg, rx_last, rx_data}),
            longint'({1'b0, 3'd2, 1'b0, 8'h3C}));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule